// File: doc/BRIEF.md
# Three-Rail Power Island Sequencer

This block is the digital controller for a power gate that routes three external supplies into a non-volatile memory core: an I/O rail (serial interface and power-on reset), a core rail of about 1 V (read path and logic) and a high-voltage rail that is needed only for programming. It tracks the operating mode of the memory: deep power-down, rails coming up, standby, read burst, write burst and rails going down. From that mode it drives one enable per rail. All timing runs on an always-on slow clock. The analog switches, the reset generator and any supply monitors are outside the block and are seen only as pins.

A wake request from the always-on domain passes through a synchronizer. On wake-up the rails are switched on strictly one at a time, and each rail gets a settle interval of `SETTLE_CYC` clock cycles. This keeps in-rush current bounded: each event lasts about half a microsecond, so `SETTLE_CYC` times the clock period must cover at least that. The write rail is switched only for write bursts, and it gets its own settle interval before the write is granted.

Bursts are requested through a valid/ready handshake. A request counts as accepted on a clock edge where both `op_valid` and `op_ready` are high. `op_ready` is high only in standby. While it is low, the requester must hold `op_valid` and `op_write` steady, and `busy` tells it why it is waiting. A burst ends with a one-cycle `op_done` pulse. A deep power-down request is taken only from standby. The rails then go down in the reverse of the wake order.

Top module: `power_island_seq`

## Requirements
- R1: During and right after reset all three rail enables, `rail_ready`, `op_ready`, `rd_active` and `wr_active` are 0, and `busy` is 1.
- R2: A wake request seen in deep power-down raises `en_io` first. `en_core` rises exactly `SETTLE_CYC` cycles later. No two rail enables ever rise in the same cycle, and `en_core` is never high without `en_io`.
- R3: `rail_ready` rises exactly `SETTLE_CYC` cycles after `en_core`. In the same cycle `busy` falls and `op_ready` rises.
- R4: While `op_ready` is 0 (off, waking, in a burst or powering down), a raised `op_valid` is not accepted and changes no output.
- R5: A read request (`op_write`=0) accepted in standby raises `rd_active` on the accepting edge, with no rail change. `op_done` returns to standby. `op_done` outside a burst is ignored.
- R6: A write request (`op_write`=1) accepted in standby raises `en_wr` on the accepting edge. `wr_active` follows exactly `SETTLE_CYC` cycles later. `op_done` clears `en_wr` and `wr_active` on the same edge.
- R7: `en_wr` is high only during the write settle interval and the write burst. It is never high during a read, and never high without `en_core` and `en_io`.
- R8: `dpd_req` is acted on only in standby. During a read or write burst it changes nothing.
- R9: An accepted power-down drops `en_core` and `rail_ready` on the accepting edge, and drops `en_io` exactly `SETTLE_CYC` cycles later. A wake request during this interval is ignored.
- R10: A wake request outside deep power-down changes no output.
- R11: In standby, when `op_valid` and `dpd_req` are both high, the burst request wins and power-down is not started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low reset from the power-on-reset circuit |
| wake_req | input | 1 | Wake request from the always-on domain (asynchronous, level) |
| dpd_req | input | 1 | Request to enter deep power-down (level) |
| op_valid | input | 1 | Burst request valid |
| op_write | input | 1 | Burst kind: 1 write, 0 read; held with `op_valid` |
| op_ready | output | 1 | Burst request can be accepted this cycle |
| op_done | input | 1 | One-cycle pulse ending the current burst |
| en_io | output | 1 | I/O rail switch enable |
| en_core | output | 1 | Core rail switch enable |
| en_wr | output | 1 | Write rail switch enable |
| rail_ready | output | 1 | I/O and core rails are settled |
| busy | output | 1 | Controller cannot accept a request now |
| rd_active | output | 1 | Read burst granted |
| wr_active | output | 1 | Write burst granted, write rail settled |

## Verification
The bench builds the block with `SETTLE_CYC`=6 and `SYNC_STAGES`=2. A full wake, write and power-down sequence therefore takes a few dozen cycles, and the exact gap between each rail edge can be measured against the parameter. The settle interval is longer than the synchronizer delay. This lets a short wake pulse arrive during power-down and die out there, so the rule that it is ignored can be tested without starting a new wake-up.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_UP_IO   = 3'd1,
    ST_UP_CORE = 3'd2,
    ST_IDLE    = 3'd3,
    ST_READ    = 3'd4,
    ST_WUP     = 3'd5,
    ST_WRITE   = 3'd6,
    ST_DN_CORE = 3'd7
  } psq_state_e;

  localparam int NRAIL   = 3;
  localparam int RAIL_IO = 0;
  localparam int RAIL_CR = 1;
  localparam int RAIL_WR = 2;

  function automatic logic rail_on(psq_state_e s, int idx);
    logic on;
    unique case (idx)
      RAIL_IO: on = (s != ST_OFF);
      RAIL_CR: on = (s == ST_UP_CORE) || (s == ST_IDLE) || (s == ST_READ) ||
                    (s == ST_WUP) || (s == ST_WRITE);
      default: on = (s == ST_WUP) || (s == ST_WRITE);
    endcase
    return on;
  endfunction

  function automatic logic rails_settled(psq_state_e s);
    return (s == ST_IDLE) || (s == ST_READ) || (s == ST_WUP) || (s == ST_WRITE);
  endfunction

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/psq_settle_timer.sv
module psq_settle_timer #(
  parameter int SETTLE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psq_mode_fsm.sv
module psq_mode_fsm
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake,
  input  logic       dpd_req,
  input  logic       op_valid,
  input  logic       op_write,
  input  logic       op_done,
  input  logic       settle_done,
  output psq_state_e state_d,
  output logic       restart
);
  psq_state_e state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     if (wake) state_d = ST_UP_IO;
      ST_UP_IO:   if (settle_done) state_d = ST_UP_CORE;
      ST_UP_CORE: if (settle_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (op_valid)     state_d = op_write ? ST_WUP : ST_READ;
        else if (dpd_req) state_d = ST_DN_CORE;
      end
      ST_READ:    if (op_done) state_d = ST_IDLE;
      ST_WUP:     if (settle_done) state_d = ST_WRITE;
      ST_WRITE:   if (op_done) state_d = ST_IDLE;
      ST_DN_CORE: if (settle_done) state_d = ST_OFF;
      default:    state_d = ST_OFF;
    endcase
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/psq_rail_drv.sv
module psq_rail_drv
  import psq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  psq_state_e       state_d,
  output logic [NRAIL-1:0] rail_en,
  output logic             rail_ready,
  output logic             busy,
  output logic             op_ready,
  output logic             rd_active,
  output logic             wr_active
);
  genvar gi;
  generate
    for (gi = 0; gi < NRAIL; gi++) begin : g_rail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rail_en[gi] <= 1'b0;
        else        rail_en[gi] <= rail_on(state_d, gi);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_ready <= 1'b0;
      busy       <= 1'b1;
      op_ready   <= 1'b0;
      rd_active  <= 1'b0;
      wr_active  <= 1'b0;
    end else begin
      rail_ready <= rails_settled(state_d);
      busy       <= (state_d != ST_IDLE);
      op_ready   <= (state_d == ST_IDLE);
      rd_active  <= (state_d == ST_READ);
      wr_active  <= (state_d == ST_WRITE);
    end
  end
endmodule

// File: rtl/power_island_seq.sv
module power_island_seq
  import psq_pkg::*;
#(
  parameter int SETTLE_CYC  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_req,
  input  logic dpd_req,
  input  logic op_valid,
  input  logic op_write,
  output logic op_ready,
  input  logic op_done,
  output logic en_io,
  output logic en_core,
  output logic en_wr,
  output logic rail_ready,
  output logic busy,
  output logic rd_active,
  output logic wr_active
);
  logic             wake_s;
  logic             settle_done;
  logic             restart;
  psq_state_e       state_d;
  logic [NRAIL-1:0] rail_en;

  psq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(wake_req), .q_sync(wake_s)
  );

  psq_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .done(settle_done)
  );

  psq_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wake(wake_s), .dpd_req(dpd_req),
    .op_valid(op_valid), .op_write(op_write), .op_done(op_done),
    .settle_done(settle_done), .state_d(state_d), .restart(restart)
  );

  psq_rail_drv u_drv (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .rail_en(rail_en),
    .rail_ready(rail_ready), .busy(busy), .op_ready(op_ready),
    .rd_active(rd_active), .wr_active(wr_active)
  );

  assign en_io   = rail_en[RAIL_IO];
  assign en_core = rail_en[RAIL_CR];
  assign en_wr   = rail_en[RAIL_WR];
endmodule

// File: rtl/psq_checker.sv
module psq_checker (
  input logic clk,
  input logic rst_n,
  input logic en_io,
  input logic en_core,
  input logic en_wr,
  input logic rail_ready,
  input logic op_ready,
  input logic busy,
  input logic rd_active,
  input logic wr_active
);
  AST_CORE_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    en_core |-> en_io); // R2

  AST_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({$rose(en_io), $rose(en_core), $rose(en_wr)}) <= 1); // R2

  AST_READY_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    rail_ready |-> (en_io && en_core)); // R3

  AST_OPREADY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (rail_ready && !rd_active && !wr_active && !en_wr)); // R4

  AST_ACT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_active && wr_active)); // R5

  AST_WR_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active |-> en_wr); // R6

  AST_WR_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |-> (en_core && en_io && !rd_active)); // R7

  AST_IO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_io) |-> (!en_core && !en_wr)); // R9

  AST_BUSY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_ready |-> busy); // R1
endmodule

bind power_island_seq psq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_io(en_io), .en_core(en_core), .en_wr(en_wr),
  .rail_ready(rail_ready), .op_ready(op_ready), .busy(busy),
  .rd_active(rd_active), .wr_active(wr_active)
);

// File: tb/power_island_seq_test.sv
module power_island_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int S          = 6;

  // vector {rd_active, wr_active, rail_ready, en_wr, en_core, en_io}
  localparam logic [5:0] V_OFF  = 6'b000000;
  localparam logic [5:0] V_IO   = 6'b000001;
  localparam logic [5:0] V_CORE = 6'b000011;
  localparam logic [5:0] V_RDY  = 6'b001011;
  localparam logic [5:0] V_RD   = 6'b101011;
  localparam logic [5:0] V_WUP  = 6'b001111;
  localparam logic [5:0] V_WR   = 6'b011111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_req = 1'b0, dpd_req = 1'b0, op_valid = 1'b0, op_write = 1'b0, op_done = 1'b0;
  logic op_ready, en_io, en_core, en_wr, rail_ready, busy, rd_active, wr_active;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cyc = 0;
  logic mon_en = 1'b0;
  logic [5:0] prev_v = V_OFF;
  logic [5:0] cur_v;
  logic [5:0] ev;
  int eg;
  string et;

  logic [5:0] exp_vec[$];
  int         exp_gap[$];
  string      exp_tag[$];

  power_island_seq #(.SETTLE_CYC(S), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .dpd_req(dpd_req),
    .op_valid(op_valid), .op_write(op_write), .op_ready(op_ready), .op_done(op_done),
    .en_io(en_io), .en_core(en_core), .en_wr(en_wr), .rail_ready(rail_ready),
    .busy(busy), .rd_active(rd_active), .wr_active(wr_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_ev(logic [5:0] v, int gap, string tag);
    exp_vec.push_back(v);
    exp_gap.push_back(gap);
    exp_tag.push_back(tag);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: every change of the output vector must match the next expected item
  always @(negedge clk) begin
    if (mon_en) begin
      cur_v = {rd_active, wr_active, rail_ready, en_wr, en_core, en_io};
      if (cur_v !== prev_v) begin
        checks++;
        if (exp_vec.size() == 0) begin
          errors++;
          $display("FAIL unexpected change actual=%b expected=%b (no event due)", cur_v, prev_v);
        end else begin
          ev = exp_vec.pop_front();
          eg = exp_gap.pop_front();
          et = exp_tag.pop_front();
          if (cur_v !== ev || (eg >= 0 && (cyc - last_cyc) != eg)) begin
            errors++;
            $display("FAIL %s actual=%b gap %0d expected=%b gap %0d",
                     et, cur_v, cyc - last_cyc, ev, eg);
          end
        end
        prev_v = cur_v;
        last_cyc = cyc;
      end
    end
  end

  task automatic wake_up(string tag);
    expect_ev(V_IO, -1, {tag, " R2 io first"});
    expect_ev(V_CORE, S, "R2 core after settle");
    expect_ev(V_RDY, S, "R3 ready after settle");
    wake_req = 1'b1;
    step(3);
    wake_req = 1'b0;
    step(2 * S + 2);
  endtask

  initial begin
    step(3);
    check("R1 en_io", en_io, 0);
    check("R1 en_core", en_core, 0);
    check("R1 en_wr", en_wr, 0);
    check("R1 rail_ready", rail_ready, 0);
    check("R1 busy", busy, 1);
    check("R1 op_ready", op_ready, 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    step(2);
    check("R1 after release busy", busy, 1);

    // R4: request while off is held off
    op_valid = 1'b1; op_write = 1'b0;
    step(4);
    check("R4 op_ready while off", op_ready, 0);
    check("R4 busy while off", busy, 1);
    op_valid = 1'b0;
    step(1);

    wake_up("first wake");
    check("R3 busy low", busy, 0);
    check("R3 op_ready high", op_ready, 1);

    // R10: wake outside deep power-down
    wake_req = 1'b1;
    step(5);
    wake_req = 1'b0;
    step(3);
    check("R10 still standby", op_ready, 1);

    // R5: read burst, with R8 dpd and R4 requests during it
    expect_ev(V_RD, -1, "R5 read grant");
    op_valid = 1'b1; op_write = 1'b0;
    step(1);
    op_valid = 1'b0;
    check("R5 rd_active", rd_active, 1);
    dpd_req = 1'b1;
    op_valid = 1'b1; op_write = 1'b1;
    step(4);
    check("R4 op_ready in read", op_ready, 0);
    check("R8 core kept in read", en_core, 1);
    dpd_req = 1'b0;
    op_valid = 1'b0;
    expect_ev(V_RDY, -1, "R5 read end");
    op_done = 1'b1;
    step(1);
    op_done = 1'b0;
    step(2);

    // R5: op_done outside a burst is ignored
    op_done = 1'b1;
    step(1);
    op_done = 1'b0;
    step(2);
    check("R5 stray done", op_ready, 1);

    // R6/R7: write burst
    check("R7 en_wr off in standby", en_wr, 0);
    expect_ev(V_WUP, -1, "R6 write rail on");
    expect_ev(V_WR, S, "R6 write grant after settle");
    op_valid = 1'b1; op_write = 1'b1;
    step(1);
    op_valid = 1'b0; op_write = 1'b0;
    dpd_req = 1'b1;
    step(S + 2);
    check("R8 dpd ignored in write", en_core, 1);
    dpd_req = 1'b0;
    expect_ev(V_RDY, -1, "R6 write end");
    op_done = 1'b1;
    step(1);
    op_done = 1'b0;
    check("R7 en_wr off after write", en_wr, 0);
    step(2);

    // R11: burst beats power-down
    expect_ev(V_RD, -1, "R11 read wins over dpd");
    op_valid = 1'b1; op_write = 1'b0; dpd_req = 1'b1;
    step(1);
    op_valid = 1'b0; dpd_req = 1'b0;
    check("R11 core kept", en_core, 1);
    expect_ev(V_RDY, -1, "R11 read end");
    op_done = 1'b1;
    step(1);
    op_done = 1'b0;
    step(2);

    // R9: power-down order, wake pulse ignored meanwhile
    expect_ev(V_IO, -1, "R9 core off first");
    expect_ev(V_OFF, S, "R9 io off after settle");
    dpd_req = 1'b1;
    step(1);
    dpd_req = 1'b0;
    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    step(S + 6);
    check("R9 off stays off", en_io, 0);
    check("R9 busy", busy, 1);

    wake_up("second wake");
    check("R3 ready again", rail_ready, 1);

    step(3);
    check("all expected events seen", exp_vec.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule